// File: doc/BRIEF.md
# Port-Size Access Splitter and Lane Steerer

This block sits between an internal 32-bit access source and an external device whose data port may be 8, 16 or 32 bits wide. It accepts one access at a time (byte, word or longword, read or write) and runs it on the external bus as one or more port-sized beats. For each beat it places write data on the right byte lanes of the 32-bit external bus and drives active-low byte enables. It also collects read bytes from those lanes back into the internal word.

The chip-select configuration is sampled when a request is accepted:
- port size;
- lane shift (left- or right-justified narrow data);
- whether byte enables are driven on reads;
- whether wide reads run as a burst.

The external side ends each beat by raising a terminate input. Accesses are assumed aligned to their own size. The internal word holds access data right-justified: a byte uses bits 7:0 and a word uses bits 15:0.

The controller has four states:
- IDLE: waits for a request.
- BEAT: chip select is asserted and the block waits for terminate.
- GAP: one idle cycle between separate sub-transfers.
- DONE: a one-cycle completion pulse.

The transitions are:
- IDLE→BEAT when a request arrives.
- BEAT→BEAT when terminate arrives on a non-final burst beat.
- BEAT→GAP when terminate arrives on a non-final split beat.
- BEAT→DONE when terminate arrives on the final beat.
- GAP→BEAT after one cycle.
- DONE→IDLE after one cycle.

Top module: `port_split_steer`

## Requirements
- R1: Port-size code 00 selects a 4-byte port, 01 a 1-byte port, and both 10 and 11 a 2-byte port. An access wider than the port takes (access bytes / port bytes) beats. Any other access takes one beat.
- R2: With lane shift clear, a narrow port occupies the top lanes of the bus: bits 31:24 for a 1-byte port and bits 31:16 for a 2-byte port.
- R3: With lane shift set, a narrow port occupies the bottom lanes: bits 7:0 for a 1-byte port and bits 15:0 for a 2-byte port.
- R4: Within a port, the most significant port lane carries the byte at the lowest address. An access narrower than the port uses the lanes selected by the beat address modulo the port width.
- R5: Byte enables are active low. bus_be_n[i] covers bits 8i+7:8i. During a write beat only the active lanes are driven low, and while chip select is deasserted all enables are high.
- R6: With byte-enables-on-read clear, a read beat keeps all enables high. With it set, the active lanes of a read beat are driven low.
- R7: A write wider than the port, or a read wider than the port with burst read disabled, runs as separate sub-transfers. After each non-final beat, chip select is deasserted for exactly one cycle and bus_burst stays low.
- R8: A read wider than the port with burst read enabled keeps chip select low across all beats, with bus_burst high during them.
- R9: The beat address starts at the request address and rises by the port width in bytes after each terminated beat.
- R10: Read beats fill the result most significant first. Reads are returned right-justified in rd_data.
- R11: done pulses for one cycle, one cycle after the final terminate, with rd_data holding the assembled word. busy is high from acceptance until done. Requests made while busy are ignored.
- R12: While terminate is low during a beat, chip select stays low and the beat address and enables hold.
- R13: After reset, chip select and all byte enables are high, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 00 byte, 01 word, 10/11 longword |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data, right-justified |
| cfg_port_size | input | 2 | Port width code |
| cfg_lane_shift | input | 1 | 1 selects right-justified lanes |
| cfg_be_on_read | input | 1 | 1 drives byte enables on reads |
| cfg_burst_read | input | 1 | 1 runs wide reads as a burst |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Assembled read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_addr | output | ADDR_W | Beat address |
| bus_write | output | 1 | Beat direction |
| bus_burst | output | 1 | Beat belongs to a burst |
| bus_be_n | output | DATA_W/8 | Byte enables, active low |
| bus_wdata | output | DATA_W | Steered write data |
| bus_rdata | input | DATA_W | External read data |
| bus_term | input | 1 | Ends the current beat |

## Verification
The hardest situations to reach are the ones that depend on what happens in the middle of a multi-beat access. These are:
- the one-cycle gap between split sub-transfers;
- a beat held open by a late terminate;
- a request arriving while an access is still running.

Each directed task drives terminate beat by beat and checks chip select in the cycle after each terminate, which tells gap from burst. One task delays terminate for several cycles and raises a second request inside that window. The later beat addresses then show that the second request was ignored.

// File: rtl/psx_pkg.sv
package psx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BEAT,
        ST_GAP,
        ST_DONE
    } psx_state_t;

    typedef struct packed {
        logic [2:0] pbytes;
        logic       shift;
        logic       be_rd;
        logic       burst_en;
    } psx_cfg_t;

    function automatic logic [2:0] access_bytes(input logic [1:0] sz);
        case (sz)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] port_bytes(input logic [1:0] ps);
        case (ps)
            2'b00:   return 3'd4;
            2'b01:   return 3'd1;
            default: return 3'd2;
        endcase
    endfunction

    function automatic logic [1:0] bytes_lg(input logic [2:0] n);
        case (n)
            3'd4:    return 2'd2;
            3'd2:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/psx_beat_plan.sv
module psx_beat_plan
    import psx_pkg::*;
(
    input  logic [2:0] acc_bytes_i,
    input  logic [2:0] port_bytes_i,
    input  logic       write_i,
    input  logic       burst_en_i,
    output logic [2:0] beat_bytes_o,
    output logic [1:0] last_beat_o,
    output logic       burst_o
);

    logic [1:0] acc_lg;
    logic [1:0] port_lg;
    logic [1:0] span_lg;
    logic       wider;

    always_comb begin
        acc_lg       = bytes_lg(acc_bytes_i);
        port_lg      = bytes_lg(port_bytes_i);
        wider        = acc_lg > port_lg;
        span_lg      = wider ? (acc_lg - port_lg) : 2'd0;
        beat_bytes_o = wider ? port_bytes_i : acc_bytes_i;
        last_beat_o  = 2'((3'd1 << span_lg) - 3'd1);
        burst_o      = !write_i && burst_en_i && wider;
    end

endmodule

// File: rtl/psx_lane_map.sv
module psx_lane_map #(
    parameter int NB = 4,
    localparam int SW = $clog2(NB)
) (
    input  logic [2:0]            port_bytes_i,
    input  logic [2:0]            acc_bytes_i,
    input  logic [2:0]            beat_bytes_i,
    input  logic                  shift_i,
    input  logic [SW-1:0]         lane_off_i,
    input  logic [1:0]            beat_idx_i,
    input  logic [8*NB-1:0]       wdata_i,
    output logic [NB-1:0]         lane_act_o,
    output logic [NB-1:0][SW-1:0] lane_src_o,
    output logic [8*NB-1:0]       wdata_o
);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        int          port_pos;
        int          rel;
        int          src;
        logic        act;
        logic [SW-1:0] src_l;
        logic [7:0]  byte_l;

        always_comb begin
            port_pos = (shift_i ? int'(port_bytes_i) - 1 : NB - 1) - b;
            rel      = port_pos - int'(lane_off_i);
            act      = (rel >= 0) && (rel < int'(beat_bytes_i));
            src      = int'(acc_bytes_i) - 1
                     - (int'(beat_idx_i) * int'(beat_bytes_i) + rel);
            src_l    = act ? SW'(src) : '0;
            byte_l   = act ? wdata_i[8*src_l +: 8] : 8'h00;
        end

        assign lane_act_o[b]      = act;
        assign lane_src_o[b]      = src_l;
        assign wdata_o[8*b +: 8]  = byte_l;
    end

endmodule

// File: rtl/psx_gather.sv
module psx_gather #(
    parameter int NB = 4,
    localparam int SW = $clog2(NB)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  capture_i,
    input  logic [NB-1:0]         lane_act_i,
    input  logic [NB-1:0][SW-1:0] lane_src_i,
    input  logic [8*NB-1:0]       rdata_i,
    output logic [8*NB-1:0]       word_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o <= '0;
        end else if (clear_i) begin
            word_o <= '0;
        end else if (capture_i) begin
            for (int b = 0; b < NB; b++) begin
                if (lane_act_i[b]) begin
                    word_o[8*lane_src_i[b] +: 8] <= rdata_i[8*b +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/port_split_steer.sv
module port_split_steer
    import psx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [1:0]          cfg_port_size,
    input  logic                cfg_lane_shift,
    input  logic                cfg_be_on_read,
    input  logic                cfg_burst_read,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   rd_data,
    output logic                bus_cs_n,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_write,
    output logic                bus_burst,
    output logic [DATA_W/8-1:0] bus_be_n,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic                bus_term
);

    localparam int NB = DATA_W / 8;
    localparam int SW = $clog2(NB);

    psx_state_t  state_q, state_d;
    psx_cfg_t    cfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    logic [2:0]        acc_bytes_q;
    logic [1:0]        beat_q;

    logic [2:0]        beat_bytes;
    logic [1:0]        last_beat;
    logic              burst_mode;
    logic [ADDR_W-1:0] beat_addr;
    logic [SW-1:0]     lane_off;
    logic [NB-1:0]     lane_act;
    logic [NB-1:0][SW-1:0] lane_src;
    logic [DATA_W-1:0] steered_wdata;
    logic              accept;
    logic              beat_end;
    logic              final_beat;

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign beat_end   = (state_q == ST_BEAT) && bus_term;
    assign final_beat = (beat_q == last_beat);
    assign beat_addr  = addr_q + ADDR_W'(beat_q) * ADDR_W'(cfg_q.pbytes);
    assign lane_off   = beat_addr[SW-1:0] & SW'(cfg_q.pbytes - 3'd1);

    psx_beat_plan i_plan (
        .acc_bytes_i  (acc_bytes_q),
        .port_bytes_i (cfg_q.pbytes),
        .write_i      (write_q),
        .burst_en_i   (cfg_q.burst_en),
        .beat_bytes_o (beat_bytes),
        .last_beat_o  (last_beat),
        .burst_o      (burst_mode)
    );

    psx_lane_map #(.NB(NB)) i_lanes (
        .port_bytes_i (cfg_q.pbytes),
        .acc_bytes_i  (acc_bytes_q),
        .beat_bytes_i (beat_bytes),
        .shift_i      (cfg_q.shift),
        .lane_off_i   (lane_off),
        .beat_idx_i   (beat_q),
        .wdata_i      (wdata_q),
        .lane_act_o   (lane_act),
        .lane_src_o   (lane_src),
        .wdata_o      (steered_wdata)
    );

    psx_gather #(.NB(NB)) i_gather (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept),
        .capture_i  (beat_end && !write_q),
        .lane_act_i (lane_act),
        .lane_src_i (lane_src),
        .rdata_i    (bus_rdata),
        .word_o     (rd_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_BEAT;
            ST_BEAT: begin
                if (bus_term) begin
                    if (final_beat)      state_d = ST_DONE;
                    else if (burst_mode) state_d = ST_BEAT;
                    else                 state_d = ST_GAP;
                end
            end
            ST_GAP:  state_d = ST_BEAT;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request and beat registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            addr_q      <= '0;
            wdata_q     <= '0;
            write_q     <= 1'b0;
            acc_bytes_q <= 3'd1;
            beat_q      <= '0;
        end else if (accept) begin
            cfg_q.pbytes   <= port_bytes(cfg_port_size);
            cfg_q.shift    <= cfg_lane_shift;
            cfg_q.be_rd    <= cfg_be_on_read;
            cfg_q.burst_en <= cfg_burst_read;
            addr_q         <= req_addr;
            wdata_q        <= req_wdata;
            write_q        <= req_write;
            acc_bytes_q    <= access_bytes(req_size);
            beat_q         <= '0;
        end else if (beat_end && !final_beat) begin
            beat_q <= beat_q + 2'd1;
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        done      = 1'b0;
        bus_cs_n  = 1'b1;
        bus_addr  = '0;
        bus_write = 1'b0;
        bus_burst = 1'b0;
        bus_be_n  = '1;
        bus_wdata = '0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_BEAT: begin
                bus_cs_n  = 1'b0;
                bus_addr  = beat_addr;
                bus_write = write_q;
                bus_burst = burst_mode;
                bus_wdata = write_q ? steered_wdata : '0;
                if (write_q || cfg_q.be_rd) bus_be_n = ~lane_act;
            end
            ST_GAP:  ;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/psx_checker.sv
module psx_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic                bus_cs_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_write,
    input logic                bus_burst,
    input logic [DATA_W/8-1:0] bus_be_n,
    input logic                bus_term
);

    a_r5_idle_enables_high: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> (bus_be_n == '1));

    a_r5_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && bus_write) |-> (bus_be_n != '1));

    a_r12_beat_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !bus_term) |=> (!bus_cs_n && $stable(bus_addr) && $stable(bus_be_n)));

    a_r7_split_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && bus_term && !bus_burst) |=> bus_cs_n);

    a_r8_burst_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_burst |-> (!bus_write && !bus_cs_n));

    a_r9_burst_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && bus_term && bus_burst) |=> (bus_cs_n || (bus_addr != $past(bus_addr))));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_follows_term: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!bus_cs_n && bus_term));

    a_r11_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && bus_cs_n));

endmodule

bind port_split_steer psx_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .bus_cs_n  (bus_cs_n),
    .bus_addr  (bus_addr),
    .bus_write (bus_write),
    .bus_burst (bus_burst),
    .bus_be_n  (bus_be_n),
    .bus_term  (bus_term)
);

// File: tb/test_port_split_steer.sv
module test_port_split_steer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  cfg_port_size = 2'b00;
    logic        cfg_lane_shift = 1'b0;
    logic        cfg_be_on_read = 1'b0;
    logic        cfg_burst_read = 1'b0;
    logic        busy, done;
    logic [31:0] rd_data;
    logic        bus_cs_n;
    logic [31:0] bus_addr;
    logic        bus_write, bus_burst;
    logic [3:0]  bus_be_n;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_term = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    port_split_steer i_port_split_steer (
        .clk, .rst_n, .req_valid, .req_write, .req_size, .req_addr, .req_wdata,
        .cfg_port_size, .cfg_lane_shift, .cfg_be_on_read, .cfg_burst_read,
        .busy, .done, .rd_data, .bus_cs_n, .bus_addr, .bus_write, .bus_burst,
        .bus_be_n, .bus_wdata, .bus_rdata, .bus_term
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input bit w, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd,
                         input logic [1:0] ps, input bit sh, input bit ber, input bit bst);
        req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
        cfg_port_size = ps; cfg_lane_shift = sh; cfg_be_on_read = ber; cfg_burst_read = bst;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        chk(busy == 1'b1, "R11 busy after accept", 32'(busy), 32'd1);
    endtask

    task automatic beat(input string tag, input logic [31:0] ea, input bit ew, input logic [31:0] ewd,
                        input logic [3:0] ebe, input bit eburst, input logic [31:0] rd, input int waits);
        chk(bus_cs_n == 1'b0, {tag, " cs low"}, 32'(bus_cs_n), 32'd0);
        chk(bus_addr == ea, {tag, " R9 addr"}, bus_addr, ea);
        chk(bus_be_n == ebe, {tag, " be_n"}, 32'(bus_be_n), 32'(ebe));
        chk(bus_burst == eburst, {tag, " burst flag"}, 32'(bus_burst), 32'(eburst));
        chk(bus_write == ew, {tag, " direction"}, 32'(bus_write), 32'(ew));
        if (ew) chk(bus_wdata == ewd, {tag, " wdata"}, bus_wdata, ewd);
        for (int i = 0; i < waits; i++) begin
            step();
            chk(bus_cs_n == 1'b0 && bus_addr == ea, {tag, " R12 hold"}, bus_addr, ea);
        end
        bus_rdata = rd;
        bus_term  = 1'b1;
        step();
        bus_term  = 1'b0;
        bus_rdata = '0;
    endtask

    task automatic gap(input string tag);
        chk(bus_cs_n == 1'b1 && done == 1'b0, {tag, " R7 gap cs high"}, 32'(bus_cs_n), 32'd1);
        step();
    endtask

    task automatic finish_access(input string tag, input bit check_rd, input logic [31:0] erd);
        chk(done == 1'b1 && bus_cs_n == 1'b1, {tag, " R11 done pulse"}, 32'(done), 32'd1);
        if (check_rd) chk(rd_data == erd, {tag, " R10 read word"}, rd_data, erd);
        step();
        chk(done == 1'b0 && busy == 1'b0, {tag, " R11 done single"}, 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        chk(bus_cs_n == 1'b1, "R13 reset cs", 32'(bus_cs_n), 32'd1);
        chk(bus_be_n == 4'hF, "R13 reset be", 32'(bus_be_n), 32'hF);
        chk(busy == 1'b0 && done == 1'b0, "R13 reset busy/done", 32'({busy, done}), 32'd0);
    endtask

    task automatic t_full_port_write();
        start(1'b1, 2'b10, 32'h100, 32'h11223344, 2'b00, 1'b0, 1'b0, 1'b0);
        beat("R1 R5 long wr 32b", 32'h100, 1'b1, 32'h11223344, 4'b0000, 1'b0, '0, 0);
        finish_access("R1 long wr 32b", 1'b0, '0);
    endtask

    task automatic t_byte_port_write_left();
        start(1'b1, 2'b10, 32'h100, 32'h11223344, 2'b01, 1'b0, 1'b0, 1'b1);
        beat("R2 R7 b0", 32'h100, 1'b1, 32'h11000000, 4'b0111, 1'b0, '0, 0);
        gap("R7 g0");
        beat("R2 R7 b1", 32'h101, 1'b1, 32'h22000000, 4'b0111, 1'b0, '0, 0);
        gap("R7 g1");
        beat("R2 R7 b2", 32'h102, 1'b1, 32'h33000000, 4'b0111, 1'b0, '0, 0);
        gap("R7 g2");
        beat("R2 R7 b3", 32'h103, 1'b1, 32'h44000000, 4'b0111, 1'b0, '0, 0);
        finish_access("R7 8b write", 1'b0, '0);
    endtask

    task automatic t_byte_port_burst_right();
        start(1'b0, 2'b10, 32'h200, '0, 2'b01, 1'b1, 1'b0, 1'b1);
        beat("R3 R8 R6 b0", 32'h200, 1'b0, '0, 4'b1111, 1'b1, 32'h000000AA, 0);
        beat("R3 R8 R6 b1", 32'h201, 1'b0, '0, 4'b1111, 1'b1, 32'h000000BB, 0);
        beat("R3 R8 R6 b2", 32'h202, 1'b0, '0, 4'b1111, 1'b1, 32'h000000CC, 0);
        beat("R3 R8 R6 b3", 32'h203, 1'b0, '0, 4'b1111, 1'b1, 32'h000000DD, 0);
        finish_access("R10 burst read", 1'b1, 32'hAABBCCDD);
    endtask

    task automatic t_half_port_word_read();
        start(1'b0, 2'b01, 32'h302, '0, 2'b11, 1'b0, 1'b1, 1'b0);
        beat("R1 R2 R6 word rd code11", 32'h302, 1'b0, '0, 4'b0011, 1'b0, 32'hBEEF1234, 0);
        finish_access("R10 word rd", 1'b1, 32'h0000BEEF);
    endtask

    task automatic t_half_port_split_read();
        start(1'b0, 2'b10, 32'h400, '0, 2'b10, 1'b1, 1'b1, 1'b0);
        beat("R3 R6 R7 s0", 32'h400, 1'b0, '0, 4'b1100, 1'b0, 32'hFFFF1234, 0);
        gap("R7 split read");
        beat("R3 R6 R7 s1", 32'h402, 1'b0, '0, 4'b1100, 1'b0, 32'hFFFF5678, 0);
        finish_access("R10 split read", 1'b1, 32'h12345678);
    endtask

    task automatic t_narrow_in_wide();
        start(1'b1, 2'b00, 32'h101, 32'h000000A5, 2'b00, 1'b0, 1'b0, 1'b0);
        beat("R4 byte off1 32b", 32'h101, 1'b1, 32'h00A50000, 4'b1011, 1'b0, '0, 0);
        finish_access("R4 a", 1'b0, '0);
        start(1'b1, 2'b00, 32'h501, 32'h000000A5, 2'b10, 1'b1, 1'b0, 1'b0);
        beat("R4 byte off1 16b right", 32'h501, 1'b1, 32'h000000A5, 4'b1110, 1'b0, '0, 0);
        finish_access("R4 b", 1'b0, '0);
        start(1'b1, 2'b00, 32'h501, 32'h000000A5, 2'b10, 1'b0, 1'b0, 1'b0);
        beat("R4 byte off1 16b left", 32'h501, 1'b1, 32'h00A50000, 4'b1011, 1'b0, '0, 0);
        finish_access("R4 c", 1'b0, '0);
        start(1'b0, 2'b00, 32'h603, '0, 2'b00, 1'b0, 1'b0, 1'b1);
        beat("R4 R6 byte rd off3", 32'h603, 1'b0, '0, 4'b1111, 1'b0, 32'h11223377, 0);
        finish_access("R10 byte rd", 1'b1, 32'h00000077);
    endtask

    task automatic t_waits_and_busy_request();
        start(1'b0, 2'b01, 32'h700, '0, 2'b01, 1'b0, 1'b1, 1'b1);
        req_valid = 1'b1; req_addr = 32'h900; req_write = 1'b1;
        beat("R12 R11 w0", 32'h700, 1'b0, '0, 4'b0111, 1'b1, 32'hAB000000, 3);
        req_valid = 1'b0;
        beat("R11 R9 w1", 32'h701, 1'b0, '0, 4'b0111, 1'b1, 32'hCD000000, 2);
        finish_access("R11 busy req ignored", 1'b1, 32'h0000ABCD);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete actual=%h expected=%h", 32'd0, 32'd1);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_full_port_write();
        t_byte_port_write_left();
        t_byte_port_burst_right();
        t_half_port_word_read();
        t_half_port_split_read();
        t_narrow_in_wide();
        t_waits_and_busy_request();
        report();
        $finish;
    end

endmodule